// File: doc/BRIEF.md
# UART Channel Interrupt Arbiter

This block gathers every interrupt cause of one serial channel and presents them to the host as one active-high request line and a 6-bit status code. The code always names the most urgent enabled cause that is waiting. Each cause is held in its own latch, and each latch has its own release rule: a line-status read, a modem-status read, a receive-data read, a holding-register write, a status-code read, or the arrival of the next received character. The receive-data-ready cause is different. It follows the receive FIFO fill level directly.

The surrounding channel supplies the event pulses, the FIFO fill counts with their trigger levels, a bit-time tick and the host access strobes. The block has no streaming data path, so every pin is a plain control or status signal. A 7-bit enable word chooses which causes may reach the outputs. Bit i of the enable word belongs to source i, numbered in priority order with 0 as the most urgent. A cause that is masked stays latched, and it shows up as soon as its enable bit is set.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset the status code is 6'b000001 and irq is 0.
- R2: Source priority runs from index 0 (highest) to index 6 (lowest), and each source has a fixed code: 0 line status 6'b000110, 1 RX ready 6'b000100, 2 RX timeout 6'b001100, 3 TX ready 6'b000010, 4 modem 6'b000000, 5 flow-character 6'b010000, 6 pin change 6'b100000. The status code names the highest-priority enabled pending source, or 6'b000001 when none is pending.
- R3: A cycle in which any bit of lsr_err[3:0] is high latches the line-status source. A lsr_rd strobe releases it.
- R4: The RX ready source is pending whenever rx_fill is nonzero and at or above rx_trig, and it is not pending otherwise.
- R5: The RX timeout source latches after 4*CHAR_BITS+12 bit_tick pulses with rx_fill nonzero and with no rx_char or rhr_rd in that span. A rhr_rd strobe releases it.
- R6: The TX ready source latches when tx_fill falls to or below tx_trig, or when tx_fill becomes zero. A thr_wr strobe or an isr_rd strobe releases it.
- R7: A cycle in which any bit of msr_delta[3:0] is high latches the modem source. A msr_rd strobe releases it.
- R8: An xon_det or xoff_det pulse latches the flow-character source, and only isr_rd releases that event. A spec_det pulse latches the same source, and either isr_rd or rx_char releases it.
- R9: A rising edge of cts_dsr_n or rts_dtr_n while afc_en is 1 latches the pin-change source, and msr_rd releases it. Edges seen while afc_en is 0 are ignored.
- R10: A source whose ier bit is 0 never appears in the code or on irq, but its latched event is kept.
- R11: When an event arrives in the same cycle as its releasing strobe, the event stays latched.
- R12: The status code holds its value for as long as isr_rd stays high.
- R13: irq is registered and equals the OR of all enabled pending sources. Outside status reads, irq is the inverse of code bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier | input | 7 | Per-source enable, bit i for source i |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| rx_fill | input | FILL_W | Receive FIFO fill count |
| rx_trig | input | FILL_W | Receive trigger level |
| rx_char | input | 1 | Pulse: one character received |
| bit_tick | input | 1 | Pulse: one bit time elapsed |
| tx_fill | input | FILL_W | Transmit FIFO fill count |
| tx_trig | input | FILL_W | Transmit trigger level |
| msr_delta | input | 4 | Modem-status delta flags |
| xon_det | input | 1 | Pulse: Xon character detected |
| xoff_det | input | 1 | Pulse: Xoff character detected |
| spec_det | input | 1 | Pulse: special character detected |
| afc_en | input | 1 | Automatic flow control enabled |
| cts_dsr_n | input | 1 | Selected flow-control input pin level |
| rts_dtr_n | input | 1 | Selected flow-control output pin level |
| isr_rd | input | 1 | Status-code register read strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| rhr_rd | input | 1 | Receive data register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Registered interrupt request, active high |
| isr_code | output | 6 | Interrupt status code |

## Verification
The assertions take it for granted that the access strobes are synchronous single-cycle or multi-cycle levels, and that the event flags are clean one-cycle pulses sampled on the clock. They also assume that ier changes only while no status read is in progress, and that rst_n is held for at least one edge. The stimulus drives every input one time unit after a rising edge, so each signal is stable across the next edge. It moves ier only between reads, and it keeps the pin levels and FIFO counts steady except when they are deliberately stepped.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 7;
  localparam int NLAT = 8;  // latch 7 keeps special-character events apart from Xon/Xoff

  localparam int SRC_LINE  = 0;
  localparam int SRC_RXRDY = 1;
  localparam int SRC_RXTO  = 2;
  localparam int SRC_TXRDY = 3;
  localparam int SRC_MODEM = 4;
  localparam int SRC_FCHAR = 5;
  localparam int SRC_PIN   = 6;
  localparam int LAT_SPEC  = 7;

  localparam logic [5:0] CODE_NONE = 6'b000001;

  function automatic logic [5:0] src_code(input int idx);
    case (idx)
      SRC_LINE:  return 6'b000110;
      SRC_RXRDY: return 6'b000100;
      SRC_RXTO:  return 6'b001100;
      SRC_TXRDY: return 6'b000010;
      SRC_MODEM: return 6'b000000;
      SRC_FCHAR: return 6'b010000;
      SRC_PIN:   return 6'b100000;
      default:   return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)         q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;   // set beats a same-cycle clear
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_idle_timer.sv
module irq_idle_timer #(
  parameter int CHAR_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic restart,
  output logic fire
);
  localparam int LIMIT = 4 * CHAR_BITS + 12;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign fire = bit_tick && !restart && (cnt_q == LIM_M1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)           cnt_q <= '0;
    else if (bit_tick && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  output logic [5:0]      code,
  output logic            any
);
  always_comb begin
    code = CODE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) code = src_code(i);
    end
    any = |pend;
  end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int FILL_W    = 7,
  parameter int CHAR_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        ier,
  input  logic [3:0]        lsr_err,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] rx_trig,
  input  logic              rx_char,
  input  logic              bit_tick,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic [FILL_W-1:0] tx_trig,
  input  logic [3:0]        msr_delta,
  input  logic              xon_det,
  input  logic              xoff_det,
  input  logic              spec_det,
  input  logic              afc_en,
  input  logic              cts_dsr_n,
  input  logic              rts_dtr_n,
  input  logic              isr_rd,
  input  logic              lsr_rd,
  input  logic              msr_rd,
  input  logic              rhr_rd,
  input  logic              thr_wr,
  output logic              irq,
  output logic [5:0]        isr_code
);
  logic [NLAT-1:0] set_v, clr_v, lat_q;
  logic [NSRC-1:0] src_act, pend;
  logic [5:0]      code_nxt;
  logic            any_nxt;
  logic            rx_empty, rx_ready, to_fire;
  logic            tx_low, tx_empty, tx_low_q, tx_empty_q;
  logic            cts_q, rts_q;

  assign rx_empty = (rx_fill == '0);
  assign rx_ready = !rx_empty && (rx_fill >= rx_trig);
  assign tx_low   = (tx_fill <= tx_trig);
  assign tx_empty = (tx_fill == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_low_q   <= 1'b1;
      tx_empty_q <= 1'b1;
      cts_q      <= 1'b1;
      rts_q      <= 1'b1;
    end else begin
      tx_low_q   <= tx_low;
      tx_empty_q <= tx_empty;
      cts_q      <= cts_dsr_n;
      rts_q      <= rts_dtr_n;
    end
  end

  irq_idle_timer #(.CHAR_BITS(CHAR_BITS)) timer_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .restart(rx_char || rhr_rd || rx_empty), .fire(to_fire)
  );

  always_comb begin
    set_v[SRC_LINE]  = |lsr_err;
    set_v[SRC_RXRDY] = rx_ready;
    set_v[SRC_RXTO]  = to_fire;
    set_v[SRC_TXRDY] = (tx_low && !tx_low_q) || (tx_empty && !tx_empty_q);
    set_v[SRC_MODEM] = |msr_delta;
    set_v[SRC_FCHAR] = xon_det || xoff_det;
    set_v[SRC_PIN]   = afc_en && ((cts_dsr_n && !cts_q) || (rts_dtr_n && !rts_q));
    set_v[LAT_SPEC]  = spec_det;

    clr_v[SRC_LINE]  = lsr_rd;
    clr_v[SRC_RXRDY] = 1'b1;          // level source: tracks rx_ready each cycle
    clr_v[SRC_RXTO]  = rhr_rd;
    clr_v[SRC_TXRDY] = isr_rd || thr_wr;
    clr_v[SRC_MODEM] = msr_rd;
    clr_v[SRC_FCHAR] = isr_rd;
    clr_v[SRC_PIN]   = msr_rd;
    clr_v[LAT_SPEC]  = isr_rd || rx_char;
  end

  irq_event_latch #(.N(NLAT)) latch_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .q_o(lat_q)
  );

  always_comb begin
    src_act            = lat_q[NSRC-1:0];
    src_act[SRC_FCHAR] = lat_q[SRC_FCHAR] || lat_q[LAT_SPEC];
    pend               = src_act & ier;
  end

  irq_prio_enc enc_i (.pend(pend), .code(code_nxt), .any(any_nxt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_code <= CODE_NONE;
      irq      <= 1'b0;
    end else begin
      irq <= any_nxt;
      if (!isr_rd) isr_code <= code_nxt;   // frozen while the status read lasts
    end
  end
endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       isr_rd,
  input logic       lsr_rd,
  input logic       msr_rd,
  input logic [3:0] lsr_err,
  input logic [3:0] msr_delta,
  input logic [6:0] ier,
  input logic       irq,
  input logic [5:0] isr_code,
  input logic       lat_line,
  input logic       lat_modem
);
  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    isr_code inside {6'b000110, 6'b000100, 6'b001100, 6'b000010,
                     6'b000000, 6'b010000, 6'b100000, 6'b000001});

  p_line_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && lsr_err == 4'b0) |=> !lat_line);

  p_modem_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && msr_delta == 4'b0) |=> !lat_modem);

  p_masked_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier[0] && !isr_rd) |=> isr_code != 6'b000110);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|lsr_err) |=> lat_line);

  p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && $past(isr_rd)) |-> $stable(isr_code));

  p_irq_match_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(isr_rd) |-> (irq == !isr_code[0]));
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .isr_rd(isr_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
  .lsr_err(lsr_err), .msr_delta(msr_delta), .ier(ier), .irq(irq),
  .isr_code(isr_code), .lat_line(lat_q[0]), .lat_modem(lat_q[4])
);

// File: tb/uart_irq_arbiter_tb_top.sv
module uart_irq_arbiter_tb_top;
  localparam int FW = 7;
  localparam int NV = 10;
  // {ier[6:0], events[6:0], expected code[5:0], expected irq}
  localparam logic [20:0] VEC [NV] = '{
    {7'h7F, 7'h7B, 6'b000110, 1'b1},
    {7'h7F, 7'h7A, 6'b000100, 1'b1},
    {7'h7F, 7'h78, 6'b000010, 1'b1},
    {7'h7F, 7'h70, 6'b000000, 1'b1},
    {7'h7F, 7'h60, 6'b010000, 1'b1},
    {7'h7F, 7'h40, 6'b100000, 1'b1},
    {7'h7E, 7'h01, 6'b000001, 1'b0},
    {7'h00, 7'h7B, 6'b000001, 1'b0},
    {7'h5F, 7'h60, 6'b100000, 1'b1},
    {7'h7F, 7'h00, 6'b000001, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [6:0] ier = 0;
  logic [3:0] lsr_err = 0, msr_delta = 0;
  logic [FW-1:0] rx_fill = 0, rx_trig = 4, tx_fill = 8, tx_trig = 4;
  logic rx_char = 0, bit_tick = 0, xon_det = 0, xoff_det = 0, spec_det = 0;
  logic afc_en = 1, cts_dsr_n = 0, rts_dtr_n = 0;
  logic isr_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
  logic irq;
  logic [5:0] isr_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_arbiter #(.FILL_W(FW), .CHAR_BITS(10)) dut_i (.*);

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [5:0] exp_code, logic exp_irq);
    checks++;
    if (isr_code !== exp_code || irq !== exp_irq) begin
      fails++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, isr_code, irq, exp_code, exp_irq);
    end
  endtask

  task automatic flush();
    rx_fill = 0;
    lsr_rd = 1; msr_rd = 1; isr_rd = 1; thr_wr = 1; rhr_rd = 1;
    step();
    lsr_rd = 0; msr_rd = 0; isr_rd = 0; thr_wr = 0; rhr_rd = 0;
    step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    chk("R1 reset", 6'b000001, 1'b0);

    // R2 priority table walk
    for (int v = 0; v < NV; v++) begin
      logic [6:0] ev;
      ier = VEC[v][20:14];
      ev  = VEC[v][13:7];
      if (ev[0]) lsr_err = 4'b0100;
      if (ev[1]) rx_fill = 4;
      if (ev[3]) tx_fill = 2;
      if (ev[4]) msr_delta = 4'b0010;
      if (ev[5]) xoff_det = 1;
      if (ev[6]) cts_dsr_n = 1;
      step();
      lsr_err = 0; msr_delta = 0; xoff_det = 0; tx_fill = 8;
      step();
      chk($sformatf("R2 vector %0d", v), VEC[v][6:1], VEC[v][0]);
      cts_dsr_n = 0;
      flush();
    end

    // R10 masked event kept, R3 release by line-status read
    ier = 0; lsr_err = 4'b1000; step(); lsr_err = 0; step();
    chk("R10 masked", 6'b000001, 1'b0);
    ier = 7'h7F; step();
    chk("R10 unmasked later", 6'b000110, 1'b1);
    lsr_rd = 1; step(); lsr_rd = 0; step();
    chk("R3 lsr read clears", 6'b000001, 1'b0);

    // R4 level tracking
    rx_fill = 5; step(2);
    chk("R4 above trigger", 6'b000100, 1'b1);
    rx_fill = 3; step(2);
    chk("R4 below trigger", 6'b000001, 1'b0);

    // R5 idle timeout: 52 ticks with fill 3
    bit_tick = 1; step(40);
    chk("R5 before limit", 6'b000001, 1'b0);
    step(20);
    chk("R5 after limit", 6'b001100, 1'b1);
    bit_tick = 0; rhr_rd = 1; step(); rhr_rd = 0; step();
    chk("R5 rhr read clears", 6'b000001, 1'b0);
    rx_fill = 0; step();

    // R6 TX ready, released by holding write, then by status read
    tx_fill = 0; step(); step();
    chk("R6 empty raises", 6'b000010, 1'b1);
    thr_wr = 1; tx_fill = 8; step(); thr_wr = 0; step();
    chk("R6 thr write clears", 6'b000001, 1'b0);
    tx_fill = 3; step(); tx_fill = 8; step();
    isr_rd = 1; step(); isr_rd = 0; step();
    chk("R6 isr read clears", 6'b000001, 1'b0);

    // R7 modem
    msr_delta = 4'b1000; step(); msr_delta = 0; step();
    chk("R7 modem raise", 6'b000000, 1'b1);
    msr_rd = 1; step(); msr_rd = 0; step();
    chk("R7 msr read clears", 6'b000001, 1'b0);

    // R8 special cleared by next char, xon not
    spec_det = 1; step(); spec_det = 0; step();
    chk("R8 special raise", 6'b010000, 1'b1);
    rx_char = 1; step(); rx_char = 0; step();
    chk("R8 rx char clears special", 6'b000001, 1'b0);
    xon_det = 1; step(); xon_det = 0; rx_char = 1; step(); rx_char = 0; step();
    chk("R8 xon survives rx char", 6'b010000, 1'b1);
    isr_rd = 1; step(); isr_rd = 0; step();
    chk("R8 isr read clears xon", 6'b000001, 1'b0);

    // R9 pin edges
    afc_en = 0; cts_dsr_n = 1; step(); step();
    chk("R9 ignored without afc", 6'b000001, 1'b0);
    cts_dsr_n = 0; afc_en = 1; step();
    rts_dtr_n = 1; step(); step();
    chk("R9 rts rise", 6'b100000, 1'b1);
    msr_rd = 1; step(); msr_rd = 0; step();
    chk("R9 msr read clears", 6'b000001, 1'b0);
    rts_dtr_n = 0; step();

    // R11 event and release strobe in the same cycle
    lsr_err = 4'b0001; lsr_rd = 1; step(); lsr_err = 0; lsr_rd = 0; step();
    chk("R11 set wins", 6'b000110, 1'b1);
    flush();

    // R12 code frozen during a status read, R13 irq follows pending
    isr_rd = 1; step();
    msr_delta = 4'b0001; step(); msr_delta = 0; step();
    chk("R12 frozen during read / R13 irq live", 6'b000001, 1'b1);
    isr_rd = 0; step();
    chk("R12 released after read", 6'b000000, 1'b1);
    flush();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule